// File: doc/BRIEF.md
# Single-Wire Pulse-Position Bit Engine (Host Side)

This block is the bit-level engine of a host on a single-wire, open-drain serial bus that idles high. Every bit slot opens with the host pulling the line low, and the moment the line is let go again carries the value: an early release means 1, a late release means 0. A third symbol, the break, is a low pulse that outlasts a whole slot. The engine sends bytes, receives bytes or single bits, and sends breaks. When receiving it notices a break coming from the far end, and it returns the decoded bit, byte or break.

A command is one strobe of `start` with an operation code, a data byte and the slot length in clock cycles. The slot length is a run-time input, so the host can be set to whichever of the bus's four speeds the device uses. Every release mark is derived from the slot length arithmetically. The line is seen through a two-flop synchronizer. `line_pull` drives an open-drain pad: 1 pulls the bus low and 0 releases it.

The controller is a five-state machine:
- IDLE: waits for `start`; the transition "accept" goes to PULL.
- PULL: drives the line low. "release" goes to RELEASE. For a break, "break-end" goes straight to GAP.
- RELEASE: the line is let go until the slot ends. At the slot end, "slot-end" goes to GAP. If a receive finds the line still low there, "abort" goes to RECOVER instead.
- RECOVER: waits for the synchronized line to read high; "line-high" goes to GAP.
- GAP: holds the line high for the recovery gap. "next-slot" goes back to PULL when bits remain; "finish" goes to IDLE and pulses `done`.

Top module: `swb_host_phy`

## Requirements
- R1: After reset `line_pull`, `busy`, `done`, `rx_break` and `rx_data` are all 0.
- R2: For each transmitted bit the line is pulled low for floor(3T/10) cycles when the bit is 1 and for floor(7T/10) cycles when it is 0, where T is the latched `slot_cycles`, which must be at least 10.
- R3: Every data slot is T cycles long from its falling edge. It is followed by a released gap of ceil(T/10) cycles before the next slot or the end of the command, so the high time after a slot's low pulse is T minus that low time plus the gap.
- R4: Bytes go out and come in least-significant bit first; a byte command takes 8 slots.
- R5: A send-break command pulls the line low for T + floor(T/2) cycles, then keeps a released gap of ceil(T/10) cycles, then completes.
- R6: In a receive slot the host pulls low for ceil(T/10) cycles, then releases. It samples the synchronized line at cycle floor(T/2) of the slot, decoding high as 1 and low as 0.
- R7: If the synchronized line is still low in the last cycle of a receive slot, the receive is aborted. No further slots start. The engine waits for the line to go high, keeps the gap, and completes with `rx_break` = 1 and `rx_data` = 0.
- R8: A receive-bit command runs one slot and returns the bit in `rx_data[0]`, with `rx_data[7:1]` = 0.
- R9: Operation codes on `op`: 0 sends `tx_byte`, 1 receives a byte, 2 sends a break, 3 receives one bit.
- R10: A `start` strobe while `busy` is 1 is ignored: the running command's slots are unchanged and no extra command runs afterwards.
- R11: `done` is a one-cycle pulse in the first idle cycle after a command, with `busy` already 0. `rx_data` and `rx_break` change only in that cycle, and only for receive commands.
- R12: `slot_cycles` is latched when a command is accepted; changing it later has no effect on that command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Command strobe, taken only when idle |
| op | input | 2 | Operation code (R9) |
| tx_byte | input | 8 | Byte to send |
| slot_cycles | input | 16 | Bit time T in clock cycles |
| line_in | input | 1 | Bus level as seen at the pad |
| line_pull | output | 1 | 1 pulls the bus low, 0 releases it |
| busy | output | 1 | A command is running |
| done | output | 1 | One-cycle completion pulse |
| rx_data | output | 8 | Last received byte or bit |
| rx_break | output | 1 | Last receive ended on a break |

## Verification
Every byte value is sent at the smallest legal slot length and received at a mid-range one. Each low-pulse width and each gap is measured against the 30%/70% and ceil(T/10) arithmetic. This exposes a swapped bit order, a misplaced release mark, or a gap rounded down to zero. Several odd slot lengths probe the floor and ceiling rounding, where an off-by-one counter would stretch every slot by a cycle. A break injected mid-byte must stop the engine after exactly four slots with zero data. A design that ignored it would run four more slots and return garbage. A stray `start` during a busy command and a slot length changed mid-command must both leave the waveform untouched; a design that re-latched either would show altered widths or an extra pulse afterwards.

// File: rtl/swb_pkg.sv
package swb_pkg;

    typedef enum logic [1:0] {
        OP_SEND_BYTE  = 2'd0,
        OP_RECV_BYTE  = 2'd1,
        OP_SEND_BREAK = 2'd2,
        OP_RECV_BIT   = 2'd3
    } swb_op_e;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_PULL    = 3'd1,
        ST_RELEASE = 3'd2,
        ST_RECOVER = 3'd3,
        ST_GAP     = 3'd4
    } swb_state_e;

endpackage

// File: rtl/swb_sync.sv
module swb_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[0] <= RESET_VAL;
                else        chain[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[i] <= RESET_VAL;
                else        chain[i] <= chain[i-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/swb_slot_marks.sv
// Derives every timing mark of a slot from the latched bit time.
module swb_slot_marks #(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] slot_len,
    output logic [CNT_W:0]   one_len,
    output logic [CNT_W:0]   zero_len,
    output logic [CNT_W:0]   mid_pt,
    output logic [CNT_W:0]   gap_len,
    output logic [CNT_W:0]   brk_len
);
    localparam int CW = CNT_W + 1;
    localparam int PW = CNT_W + 5;

    logic [PW-1:0] t_w;
    assign t_w = PW'(slot_len);

    assign one_len  = CW'((t_w * PW'(3)) / PW'(10));
    assign zero_len = CW'((t_w * PW'(7)) / PW'(10));
    assign mid_pt   = CW'(t_w >> 1);
    assign gap_len  = CW'((t_w + PW'(9)) / PW'(10));
    assign brk_len  = CW'(t_w + (t_w >> 1));
endmodule

// File: rtl/swb_ctrl.sv
module swb_ctrl
    import swb_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        op_in,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic [CNT_W-1:0]  slot_cycles,
    input  logic              line_s,
    input  logic [CNT_W:0]    one_len,
    input  logic [CNT_W:0]    zero_len,
    input  logic [CNT_W:0]    mid_pt,
    input  logic [CNT_W:0]    gap_len,
    input  logic [CNT_W:0]    brk_len,
    output logic [CNT_W-1:0]  slot_len_q,
    output logic              line_pull,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_break
);
    localparam int CW    = CNT_W + 1;
    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

    swb_state_e        st_q, st_d;
    swb_op_e           op_q;
    logic [CW-1:0]     cnt_q, cnt_d;
    logic [CW-1:0]     low_len, slot_last;
    logic [IDX_W-1:0]  bit_idx_q;
    logic [DATA_W-1:0] txd_q, shreg_q, rx_data_q;
    logic              abort_q, rx_break_q, done_q;
    logic              is_rx, at_end, at_mid, pull_over, gap_over;
    logic              still_low, more_slots, finish;

    // Slot decode
    always_comb begin
        unique case (op_q)
            OP_SEND_BYTE:  low_len = txd_q[0] ? one_len : zero_len;
            OP_SEND_BREAK: low_len = brk_len;
            default:       low_len = gap_len;
        endcase
    end

    assign slot_last  = CW'(slot_len_q) - CW'(1);
    assign is_rx      = (op_q == OP_RECV_BYTE) || (op_q == OP_RECV_BIT);
    assign at_end     = (cnt_q == slot_last);
    assign at_mid     = (cnt_q == mid_pt);
    assign pull_over  = (cnt_q == low_len - CW'(1));
    assign gap_over   = (cnt_q == gap_len - CW'(1));
    assign still_low  = is_rx && at_end && !line_s;
    assign more_slots = !abort_q && (op_q != OP_SEND_BREAK) &&
                        (op_q != OP_RECV_BIT) && (bit_idx_q != LAST_IDX);

    // Next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:    if (start)     st_d = ST_PULL;
            ST_PULL:    if (pull_over) st_d = (op_q == OP_SEND_BREAK) ? ST_GAP : ST_RELEASE;
            ST_RELEASE: if (at_end)    st_d = still_low ? ST_RECOVER : ST_GAP;
            ST_RECOVER: if (line_s)    st_d = ST_GAP;
            ST_GAP:     if (gap_over)  st_d = more_slots ? ST_PULL : ST_IDLE;
            default:                   st_d = ST_IDLE;
        endcase
    end

    // Slot counter runs across PULL->RELEASE, restarts on every other change
    always_comb begin
        if (st_d == ST_IDLE || st_d == ST_RECOVER) begin
            cnt_d = '0;
        end else if (st_d != st_q && !(st_q == ST_PULL && st_d == ST_RELEASE)) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + CW'(1);
        end
    end

    assign finish = (st_q == ST_GAP) && (st_d == ST_IDLE);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q       <= OP_SEND_BYTE;
            txd_q      <= '0;
            slot_len_q <= '0;
            bit_idx_q  <= '0;
            shreg_q    <= '0;
            abort_q    <= 1'b0;
            rx_data_q  <= '0;
            rx_break_q <= 1'b0;
            done_q     <= 1'b0;
        end else begin
            done_q <= finish;
            if (st_q == ST_IDLE && start) begin
                op_q       <= swb_op_e'(op_in);
                txd_q      <= tx_byte;
                slot_len_q <= slot_cycles;
                bit_idx_q  <= '0;
                shreg_q    <= '0;
                abort_q    <= 1'b0;
            end
            if (st_q == ST_RELEASE && is_rx && at_mid) begin
                shreg_q <= {line_s, shreg_q[DATA_W-1:1]};
            end
            if (st_q == ST_RELEASE && still_low) begin
                abort_q <= 1'b1;
            end
            if (st_q == ST_GAP && st_d == ST_PULL) begin
                bit_idx_q <= bit_idx_q + IDX_W'(1);
                txd_q     <= txd_q >> 1;
            end
            if (finish && is_rx) begin
                rx_break_q <= abort_q;
                if (abort_q)                 rx_data_q <= '0;
                else if (op_q == OP_RECV_BIT) rx_data_q <= DATA_W'(shreg_q[DATA_W-1]);
                else                         rx_data_q <= shreg_q;
            end
        end
    end

    assign line_pull = (st_q == ST_PULL);
    assign busy      = (st_q != ST_IDLE);
    assign done      = done_q;
    assign rx_data   = rx_data_q;
    assign rx_break  = rx_break_q;
endmodule

// File: rtl/swb_host_phy.sv
module swb_host_phy #(
    parameter int DATA_W      = 8,
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        op,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic [CNT_W-1:0]  slot_cycles,
    input  logic              line_in,
    output logic              line_pull,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_break
);
    logic             line_s;
    logic [CNT_W-1:0] slot_len_q;
    logic [CNT_W:0]   one_len, zero_len, mid_pt, gap_len, brk_len;

    swb_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (line_in),
        .q     (line_s)
    );

    swb_slot_marks #(.CNT_W(CNT_W)) u_marks (
        .slot_len (slot_len_q),
        .one_len  (one_len),
        .zero_len (zero_len),
        .mid_pt   (mid_pt),
        .gap_len  (gap_len),
        .brk_len  (brk_len)
    );

    swb_ctrl #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .op_in       (op),
        .tx_byte     (tx_byte),
        .slot_cycles (slot_cycles),
        .line_s      (line_s),
        .one_len     (one_len),
        .zero_len    (zero_len),
        .mid_pt      (mid_pt),
        .gap_len     (gap_len),
        .brk_len     (brk_len),
        .slot_len_q  (slot_len_q),
        .line_pull   (line_pull),
        .busy        (busy),
        .done        (done),
        .rx_data     (rx_data),
        .rx_break    (rx_break)
    );
endmodule

// File: rtl/swb_host_phy_chk.sv
module swb_host_phy_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              line_pull,
    input logic              busy,
    input logic              done,
    input logic [DATA_W-1:0] rx_data,
    input logic              rx_break
);
    p_pull_only_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        line_pull |-> busy);

    p_gap_after_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(line_pull) |=> !line_pull);

    p_busy_needs_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_idle_with_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    p_rx_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(rx_data) || !$stable(rx_break)) |-> done);
endmodule

bind swb_host_phy swb_host_phy_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/swb_host_phy_tb.sv
module swb_host_phy_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  op = 2'd0;
    logic [7:0]  tx_byte = 8'd0;
    logic [15:0] slot_cycles = 16'd10;
    logic        line_in;
    logic        line_pull, busy, done, rx_break;
    logic [7:0]  rx_data;
    logic        dev_low = 1'b0;

    assign line_in = !(line_pull || dev_low);
    always #(CLK_PERIOD/2) clk = ~clk;

    swb_host_phy u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .tx_byte(tx_byte),
        .slot_cycles(slot_cycles), .line_in(line_in), .line_pull(line_pull),
        .busy(busy), .done(done), .rx_data(rx_data), .rx_break(rx_break)
    );

    int checks = 0;
    int errors = 0;
    int low_w[16];
    int high_w[16];
    int n_low, tail;
    bit got_done;

    // Bus device model: answers each host slot by holding the line low
    bit   dev_en = 1'b0;
    int   dev_byte = 0, dev_brk = 99, dev_slot = 0, dev_cnt = 0, dev_t = 20, dev_hold = 0;
    logic prev_pull = 1'b0;

    always @(negedge clk) begin
        if (dev_en && line_pull && !prev_pull) begin
            if (dev_slot == dev_brk)               dev_hold = 2 * dev_t;
            else if (((dev_byte >> (dev_slot % 8)) & 1) == 1) dev_hold = (dev_t * 3) / 10;
            else                                   dev_hold = (dev_t * 7) / 10;
            dev_cnt  = dev_hold;
            dev_slot = dev_slot + 1;
        end
        dev_low = (dev_cnt > 0);
        if (dev_cnt > 0) dev_cnt = dev_cnt - 1;
        prev_pull = line_pull;
    end

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Issue one command (called at a negedge) and measure line_pull runs until done
    task automatic run_op(int opc, int data, int t, int inj_start_at, int inj_t_at, int inj_t);
        int  run;
        bit  prev;
        op = 2'(opc); tx_byte = 8'(data); slot_cycles = 16'(t); start = 1'b1;
        n_low = 0; run = 0; prev = 1'b0; tail = 0; got_done = 1'b0;
        for (int c = 0; c < 30000; c++) begin
            @(negedge clk);
            start = (c == inj_start_at);
            if (c == inj_start_at) op = 2'd2;
            if (c == inj_t_at) slot_cycles = 16'(inj_t);
            if (done) begin
                got_done = 1'b1;
                tail = run;
                break;
            end
            if (line_pull) begin
                if (!prev) begin
                    if (n_low > 0 && n_low <= 16) high_w[n_low-1] = run;
                    run = 0;
                end
                run++;
            end else begin
                if (prev) begin
                    if (n_low < 16) low_w[n_low] = run;
                    n_low++;
                    run = 0;
                end
                run++;
            end
            prev = line_pull;
        end
        start = 1'b0;
        check(got_done, "R11", "command completed", int'(got_done), 1);
        check(!busy, "R11", "busy low with done", int'(busy), 0);
        @(negedge clk);
        check(!done, "R11", "done pulse width", int'(done), 0);
    endtask

    // Check a measured transmit waveform for byte b at bit time t
    task automatic check_tx(int b, int t);
        int g = (t + 9) / 10;
        int lw;
        check(n_low == 8, "R4", "slot count", n_low, 8);
        if (n_low == 8) begin
            for (int i = 0; i < 8; i++) begin
                lw = (((b >> i) & 1) == 1) ? (t * 3) / 10 : (t * 7) / 10;
                check(low_w[i] == lw, "R2", $sformatf("low width b=%0h t=%0d slot %0d", b, t, i), low_w[i], lw);
                if (i < 7)
                    check(high_w[i] == t - lw + g, "R3", $sformatf("high+gap b=%0h t=%0d slot %0d", b, t, i), high_w[i], t - lw + g);
                else
                    check(tail == t - lw + g, "R3", $sformatf("tail b=%0h t=%0d", b, t), tail, t - lw + g);
            end
        end
    endtask

    task automatic rx_run(int b, int t, int brk_at, int opc);
        dev_byte = b; dev_brk = brk_at; dev_slot = 0; dev_t = t; dev_en = 1'b1;
        run_op(opc, 0, t, -1, -1, 0);
        dev_en = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        checks++; errors++;
        $display("FAIL R11 watchdog expired: actual 0 expected 1");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int tlist[6];
        int blist[4];
        int quiet;
        tlist = '{10, 13, 17, 20, 37, 64};
        blist = '{8'h00, 8'hFF, 8'hA5, 8'h3C};

        repeat (5) @(negedge clk);
        // R1 reset state
        check(line_pull == 1'b0, "R1", "line_pull in reset", int'(line_pull), 0);
        check(busy == 1'b0, "R1", "busy in reset", int'(busy), 0);
        check(done == 1'b0, "R1", "done in reset", int'(done), 0);
        check(rx_data == 8'd0, "R1", "rx_data in reset", int'(rx_data), 0);
        check(rx_break == 1'b0, "R1", "rx_break in reset", int'(rx_break), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(!line_pull && !busy, "R1", "idle after reset", int'(busy), 0);

        // R2 R3 R4 R9: every byte at the shortest slot
        for (int b = 0; b < 256; b++) begin
            run_op(0, b, 10, -1, -1, 0);
            check_tx(b, 10);
        end
        // R2 R3: rounding at odd slot lengths
        for (int ti = 0; ti < 6; ti++) begin
            for (int bi = 0; bi < 4; bi++) begin
                run_op(0, blist[bi], tlist[ti], -1, -1, 0);
                check_tx(blist[bi], tlist[ti]);
            end
        end

        // R5 send break
        for (int ti = 0; ti < 6; ti++) begin
            run_op(2, 0, tlist[ti], -1, -1, 0);
            check(n_low == 1, "R5", "break pulse count", n_low, 1);
            check(low_w[0] == tlist[ti] + tlist[ti] / 2, "R5", $sformatf("break width t=%0d", tlist[ti]),
                  low_w[0], tlist[ti] + tlist[ti] / 2);
            check(tail == (tlist[ti] + 9) / 10, "R5", "gap after break", tail, (tlist[ti] + 9) / 10);
        end

        // R4 R6: receive every byte value
        for (int b = 0; b < 256; b++) begin
            rx_run(b, 20, 99, 1);
            check(rx_data == 8'(b), "R6", "received byte", int'(rx_data), b);
            check(rx_break == 1'b0, "R6", "no break on clean byte", int'(rx_break), 0);
            check(n_low == 8 && low_w[0] == 2 && low_w[7] == 2, "R6", "receive start pulse", low_w[0], 2);
        end
        rx_run(8'h6B, 30, 99, 1);
        check(rx_data == 8'h6B, "R4", "received byte t=30", int'(rx_data), 8'h6B);
        rx_run(8'hD2, 40, 99, 1);
        check(rx_data == 8'hD2, "R4", "received byte t=40", int'(rx_data), 8'hD2);

        // R8 single bit
        rx_run(8'hFF, 20, 99, 1);
        rx_run(8'h00, 20, 99, 3);
        check(rx_data == 8'h00, "R8", "single bit 0", int'(rx_data), 0);
        check(n_low == 1, "R8", "single bit slot count", n_low, 1);
        rx_run(8'h01, 20, 99, 3);
        check(rx_data == 8'h01, "R8", "single bit 1", int'(rx_data), 1);

        // R7 break during receive
        rx_run(8'h55, 20, 3, 1);
        check(rx_break == 1'b1, "R7", "break flagged", int'(rx_break), 1);
        check(rx_data == 8'h00, "R7", "data cleared on break", int'(rx_data), 0);
        check(n_low == 4, "R7", "slots before abort", n_low, 4);
        check(dev_low == 1'b0, "R7", "completes after line high", int'(dev_low), 0);
        rx_run(8'h9C, 20, 99, 1);
        check(rx_break == 1'b0 && rx_data == 8'h9C, "R7", "clean receive after break", int'(rx_data), 8'h9C);

        // R11 transmit leaves receive results alone
        run_op(0, 8'h12, 10, -1, -1, 0);
        check(rx_data == 8'h9C, "R11", "rx_data kept over transmit", int'(rx_data), 8'h9C);

        // R12 slot length change mid-command
        run_op(0, 8'hC3, 10, -1, 3, 37);
        check_tx(8'hC3, 10);
        check(n_low == 8, "R12", "latched slot length", n_low, 8);

        // R10 start while busy
        run_op(0, 8'h0F, 20, 25, -1, 0);
        check_tx(8'h0F, 20);
        quiet = 1;
        for (int c = 0; c < 40; c++) begin
            @(negedge clk);
            if (busy || line_pull) quiet = 0;
        end
        check(quiet == 1, "R10", "no command after ignored start", quiet, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule